// File: doc/BRIEF.md
# Multi-Input Switch Debouncer

This block cleans up a small bank of mechanical switch inputs (up to eight lanes) that are sampled on a periodic strobe. Each strobe pulse is one tick. On each tick, every lane is sampled after an optional per-lane inversion. This lets an active-low switch present the same polarity as the others. The block keeps a short history of the samples. A lane's filtered level changes only when the current sample and the stored history all agree.

Next to the filtered levels, the block produces a per-lane change mask. The mask marks the lanes whose filtered level moved on the most recent tick. It holds until the next tick replaces it, so logic downstream can act on the edges at the tick rate. The strobe generator and any queuing of these edges belong to the surrounding design.

At reset, chosen lanes can start with a preset filtered level and a preset change flag. For example, a lane that is known to be active at power-up can announce itself on the first cycle.

Top module: `switch_debouncer`

## Requirements
- R1: While reset is asserted, and until the first tick after it, `deb_state` equals PRESET_STATE and `deb_toggle` equals PRESET_TOGGLE (defaults 6'b001000 for both). The sample history is cleared to zero.
- R2: `deb_state` and `deb_toggle` change only in the clock cycle after a cycle with `sample_tick` high. Input activity between ticks has no effect on them.
- R3: Each tick shifts the history. The new conditioned sample enters the youngest position and the oldest is discarded, so DEPTH (default 3) consecutive tick samples form the decision window.
- R4: A lane is stable on a tick when its new sample equals every stored history entry. A stable lane's filtered level takes the sample value on that tick.
- R5: A lane whose window samples disagree keeps its filtered level and never raises its change flag.
- R6: On each tick, `deb_toggle` is rewritten with, for each stable lane, the XOR of the sample and the previous filtered level. A flag therefore lasts exactly one tick period.
- R7: Lanes set in INVERT_MASK (default 6'b010000, lane 4) are inverted before they are sampled. A low level on such a lane is debounced as a 1.
- R8: After a clean level change on a lane, the filtered level updates on the DEPTH-th tick that samples the new level. With DEPTH=3, this is two to three tick periods after the change.
- R9: Lanes are independent: bouncing on one lane does not delay or block a change on another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle strobe that marks a sampling tick |
| sw_raw | input | WIDTH | Raw switch levels |
| deb_state | output | WIDTH | Debounced levels |
| deb_toggle | output | WIDTH | Lanes whose debounced level changed on the last tick |

## Verification
The bench builds the block with its defaults: six lanes, a three-deep window, lane 4 inverted, and lane 3 preset both high and flagged. Lane 4 being inverted means an all-zero input is not a neutral pattern, so the inversion path shows up in the outputs from the first ticks. The preset lane checks that the reset flag is dropped on the first tick. Random bouncing on chosen lanes, mixed with held levels on others, reaches both the window-disagree path and changes on independent lanes in the same tick.

// File: rtl/swdb_pkg.sv
package swdb_pkg;
   localparam int unsigned SWDB_MAX_LANES = 8;
   localparam int unsigned SWDB_MIN_DEPTH = 2;
   localparam int unsigned SWDB_MAX_DEPTH = 8;

   // True when a lane count is legal for this library block
   function automatic bit swdb_width_ok(input int unsigned w);
      return (w >= 1) && (w <= SWDB_MAX_LANES);
   endfunction

   function automatic bit swdb_depth_ok(input int unsigned d);
      return (d >= SWDB_MIN_DEPTH) && (d <= SWDB_MAX_DEPTH);
   endfunction
endpackage

// File: rtl/swdb_sample_chain.sv
module swdb_sample_chain #(
   parameter int unsigned WIDTH = 6,
   parameter int unsigned DEPTH = 3,
   parameter logic [WIDTH-1:0] INVERT_MASK = 6'b010000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sample_tick,
   input  logic [WIDTH-1:0]             sw_raw,
   output logic [WIDTH-1:0]             cur_sample,
   output logic [WIDTH*(DEPTH-1)-1:0]   hist_flat
);
   localparam int unsigned STAGES = DEPTH - 1;

   logic [WIDTH-1:0] hist_q [STAGES];

   assign cur_sample = sw_raw ^ INVERT_MASK;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n)           hist_q[0] <= '0;
            else if (sample_tick) hist_q[0] <= cur_sample;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n)           hist_q[s] <= '0;
            else if (sample_tick) hist_q[s] <= hist_q[s-1];
         end
      end
      assign hist_flat[s*WIDTH +: WIDTH] = hist_q[s];
   end

   // R3: the youngest history entry captures the conditioned sample of the tick
   assert_hist_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> hist_flat[WIDTH-1:0] == $past(cur_sample));

   // R7: inverted lanes enter the chain opposite to the pin level
   assert_invert_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> ((hist_flat[WIDTH-1:0] ^ $past(sw_raw)) == INVERT_MASK));

   // R2: history holds between ticks
   assert_hist_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> $stable(hist_flat));
endmodule

// File: rtl/swdb_stability.sv
module swdb_stability #(
   parameter int unsigned WIDTH = 6,
   parameter int unsigned DEPTH = 3
) (
   input  logic [WIDTH-1:0]             cur_sample,
   input  logic [WIDTH*(DEPTH-1)-1:0]   hist_flat,
   output logic [WIDTH-1:0]             stable_mask
);
   localparam int unsigned STAGES = DEPTH - 1;

   always_comb begin
      stable_mask = '1;
      for (int s = 0; s < STAGES; s++) begin
         stable_mask = stable_mask & ~(cur_sample ^ hist_flat[s*WIDTH +: WIDTH]);
      end
   end
endmodule

// File: rtl/swdb_state_reg.sv
module swdb_state_reg #(
   parameter int unsigned WIDTH = 6,
   parameter logic [WIDTH-1:0] PRESET_STATE  = 6'b001000,
   parameter logic [WIDTH-1:0] PRESET_TOGGLE = 6'b001000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_tick,
   input  logic [WIDTH-1:0] cur_sample,
   input  logic [WIDTH-1:0] stable_mask,
   output logic [WIDTH-1:0] deb_state,
   output logic [WIDTH-1:0] deb_toggle
);
   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] toggle_q;
   logic [WIDTH-1:0] flip;

   assign flip = stable_mask & (cur_sample ^ state_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= PRESET_STATE;
         toggle_q <= PRESET_TOGGLE;
      end else if (sample_tick) begin
         state_q  <= state_q ^ flip;
         toggle_q <= flip;
      end
   end

   assign deb_state  = state_q;
   assign deb_toggle = toggle_q;

   // R2: outputs hold on cycles without a tick
   assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> $stable(deb_state) && $stable(deb_toggle));

   // R4: stable lanes follow the sample
   assert_stable_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> ((deb_state ^ $past(cur_sample)) & $past(stable_mask)) == '0);

   // R5: disagreeing lanes neither move nor flag
   assert_bounce_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> ((deb_toggle | (deb_state ^ $past(deb_state))) & ~$past(stable_mask)) == '0);

   // R6: the flag mask marks exactly the lanes that moved
   assert_flag_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> deb_toggle == (deb_state ^ $past(deb_state)));
endmodule

// File: rtl/switch_debouncer.sv
module switch_debouncer
   import swdb_pkg::*;
#(
   parameter int unsigned WIDTH = 6,
   parameter int unsigned DEPTH = 3,
   parameter logic [WIDTH-1:0] INVERT_MASK   = 6'b010000,
   parameter logic [WIDTH-1:0] PRESET_STATE  = 6'b001000,
   parameter logic [WIDTH-1:0] PRESET_TOGGLE = 6'b001000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_tick,
   input  logic [WIDTH-1:0] sw_raw,
   output logic [WIDTH-1:0] deb_state,
   output logic [WIDTH-1:0] deb_toggle
);
   localparam int unsigned HIST_BITS = WIDTH * (DEPTH - 1);

   if (!swdb_width_ok(WIDTH)) begin : g_bad_width
      $error("switch_debouncer: WIDTH must be 1..8");
   end
   if (!swdb_depth_ok(DEPTH)) begin : g_bad_depth
      $error("switch_debouncer: DEPTH must be 2..8");
   end

   logic [WIDTH-1:0]     cur_sample;
   logic [HIST_BITS-1:0] hist_flat;
   logic [WIDTH-1:0]     stable_mask;

   swdb_sample_chain #(
      .WIDTH(WIDTH), .DEPTH(DEPTH), .INVERT_MASK(INVERT_MASK)
   ) u_chain (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
      .sw_raw(sw_raw), .cur_sample(cur_sample), .hist_flat(hist_flat)
   );

   swdb_stability #(
      .WIDTH(WIDTH), .DEPTH(DEPTH)
   ) u_stab (
      .cur_sample(cur_sample), .hist_flat(hist_flat), .stable_mask(stable_mask)
   );

   swdb_state_reg #(
      .WIDTH(WIDTH), .PRESET_STATE(PRESET_STATE), .PRESET_TOGGLE(PRESET_TOGGLE)
   ) u_state (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
      .cur_sample(cur_sample), .stable_mask(stable_mask),
      .deb_state(deb_state), .deb_toggle(deb_toggle)
   );

   // R1: reset values at the outputs
   assert_reset_values_R1: assert property (@(posedge clk)
      !rst_n |=> deb_state == PRESET_STATE && deb_toggle == PRESET_TOGGLE);
endmodule

// File: tb/switch_debouncer_bench.sv
module switch_debouncer_bench;
   localparam int W = 6;
   localparam logic [W-1:0] INV  = 6'b010000;
   localparam logic [W-1:0] PST  = 6'b001000;
   localparam logic [W-1:0] PTG  = 6'b001000;

   logic clk = 1'b0;
   logic rst_n;
   logic sample_tick;
   logic [W-1:0] sw_raw;
   logic [W-1:0] deb_state, deb_toggle;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   // reference model
   logic [W-1:0] m_h0, m_h1, m_state, m_tog;

   always #2.5 clk = ~clk;

   switch_debouncer u_switch_debouncer (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
      .sw_raw(sw_raw), .deb_state(deb_state), .deb_toggle(deb_toggle)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] model_flip(input logic [W-1:0] cur);
      logic [W-1:0] agree;
      agree = ~(cur ^ m_h0) & ~(m_h0 ^ m_h1);
      return agree & (cur ^ m_state);
   endfunction

   task automatic model_tick(input logic [W-1:0] raw);
      logic [W-1:0] cur, f;
      cur = raw ^ INV;
      f = model_flip(cur);
      m_state = m_state ^ f;
      m_tog = f;
      m_h1 = m_h0;
      m_h0 = cur;
   endtask

   // one tick, then compare both outputs with the model
   task automatic do_tick(input logic [W-1:0] raw, input string req);
      @(negedge clk);
      sw_raw = raw;
      sample_tick = 1'b1;
      @(posedge clk);
      model_tick(raw);
      @(negedge clk);
      sample_tick = 1'b0;
      check({req, " state"}, deb_state, m_state);
      check({req, " toggle"}, deb_toggle, m_tog);
   endtask

   // idle cycle with changing input and no tick: outputs must hold (R2)
   task automatic idle_cycle(input logic [W-1:0] raw);
      @(negedge clk);
      sw_raw = raw;
      sample_tick = 1'b0;
      @(negedge clk);
      check("R2 hold state", deb_state, m_state);
      check("R2 hold toggle", deb_toggle, m_tog);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: actual running expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] target, glitch, r;
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      sample_tick = 1'b1;
      sw_raw = 6'b111111;
      m_h0 = '0; m_h1 = '0; m_state = PST; m_tog = PTG;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset state", deb_state, PST);
      check("R1 reset toggle", deb_toggle, PTG);
      sample_tick = 1'b0;
      rst_n = 1'b1;
      idle_cycle(6'b101010);
      check("R1 after release", deb_state, 6'b001000);

      // neutral pattern: lane 4 high at the pin (released), lane 3 high
      do_tick(6'b011000, "R6 first tick");
      check("R6 preset flag cleared", deb_toggle, 6'b000000);
      do_tick(6'b011000, "R3");
      do_tick(6'b011000, "R3");
      check("R4 neutral state", deb_state, 6'b001000);

      // clean rise on lane 0: moves on the third sampling tick (R8)
      do_tick(6'b011001, "R8 t1");
      check("R8 t1 no change", deb_state, 6'b001000);
      do_tick(6'b011001, "R8 t2");
      check("R8 t2 no change", deb_state, 6'b001000);
      do_tick(6'b011001, "R8 t3");
      check("R8 t3 state", deb_state, 6'b001001);
      check("R6 flag lane0", deb_toggle, 6'b000001);
      do_tick(6'b011001, "R6 next");
      check("R6 flag dropped", deb_toggle, 6'b000000);

      // inverted lane 4 pulled low reads as active (R7)
      do_tick(6'b001001, "R7");
      do_tick(6'b001001, "R7");
      do_tick(6'b001001, "R7");
      check("R7 inverted lane state", deb_state, 6'b011001);
      check("R7 inverted lane flag", deb_toggle, 6'b010000);

      // lane 1 bounces while lane 5 rises cleanly (R5, R9)
      do_tick(6'b101011, "R9");
      do_tick(6'b101001, "R9");
      do_tick(6'b101011, "R9");
      check("R9 lane5 moved despite lane1 bounce", deb_state, 6'b111001);
      check("R5 bouncing lane no flag", deb_toggle, 6'b100000);
      do_tick(6'b101001, "R5");
      do_tick(6'b101011, "R5");
      check("R5 bouncing lane held", deb_state & 6'b000010, 6'b000000);

      // random levels with sparse glitches, idle cycles between ticks
      target = 6'b011000;
      for (int i = 0; i < 600; i++) begin
         if (($urandom % 8) == 0) target = target ^ (6'b1 << ($urandom % W));
         glitch = '0;
         if (($urandom % 3) == 0) glitch = 6'($urandom) & 6'($urandom);
         r = target ^ glitch;
         do_tick(r, "R4 random");
         if (($urandom % 4) == 0) idle_cycle(6'($urandom));
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule